// File: doc/BRIEF.md
# Ready-Latency TLP Transmit Packer

This block turns a transaction-layer packet description into a sequence of 64-bit beats on a streaming transmit port. A description has a four-dword header, a payload length in dwords and up to `MAX_DW` payload dwords. The header always takes two beats. The payload follows it, two dwords per beat. When the request address does not sit on a qword boundary, the block leaves one empty dword slot ahead of the payload.

The transmit port has no same-cycle handshake. Its ready input applies with a fixed latency of `READY_LAT` cycles, which is two by default. A beat may be presented in a cycle only if ready was high two cycles earlier. While the port is stalled, the pending beat is held steady on the data lines. A new description is accepted while the final beat of the current packet goes out, so packets follow each other with no idle cycle between them.

Top module: `tlp_tx_packer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `tx_valid`, `tx_sop` and `tx_eop` are low.
- R2: Every packet begins with two header beats. The first beat carries header dword 0 on bits [31:0] and dword 1 on bits [63:32], and it is the only beat with `tx_sop` high. The second beat carries dword 2 low and dword 3 high. Header dword i enters on `pkt_hdr[32*i+31:32*i]`.
- R3: When bit 2 of header dword 3 (`pkt_hdr[98]`) is clear, payload dword 0 is in the low half of the third beat. Each later dword takes the next half, low half before high half.
- R4: When `pkt_hdr[98]` is set and the length is nonzero, the low half of the third beat is zero and payload dword 0 is in its high half. Later dwords go on filling low half, then high half.
- R5: `tx_eop` is high on the final beat only. When the final beat carries a single dword, that dword is in the low half and bits [63:32] are zero.
- R6: `tx_valid` is high in a cycle only if `tx_ready` was high two cycles earlier.
- R7: If `tx_ready` was high two cycles earlier and a beat is pending, that beat is presented. While a stall holds it back, `tx_data` shows that beat unchanged, and no beat is lost or repeated.
- R8: If a new description is offered during the eop beat, its sop beat is presented in the very next cycle, provided ready allows it.
- R9: `pkt_ready` is high when no packet is in flight, or when the final beat of the current one is presented. A description is taken when `pkt_valid` and `pkt_ready` are both high, and `pkt_len` must not exceed `MAX_DW`.
- R10: A zero-length packet consists of the two header beats only, whatever the value of the address bit. `tx_eop` is high on the second beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet description is offered |
| pkt_ready | output | 1 | The description is taken this cycle if offered |
| pkt_hdr | input | 128 | Four header dwords, dword i in bits [32i+31:32i] |
| pkt_len | input | LEN_W | Payload length in dwords, 0..MAX_DW |
| pkt_payload | input | 32*MAX_DW | Payload dwords, dword k in bits [32k+31:32k] |
| tx_ready | input | 1 | Transmit ready, with a latency of READY_LAT cycles |
| tx_valid | output | 1 | A beat is presented |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| tx_data | output | 64 | Beat data, lower dword on bits [31:0] |

## Verification
A faulty ready history shows within two cycles of any change in `tx_ready`. The symptom is a beat presented inside a stall, or a beat withheld when ready allowed it, and the cycle-level model catches either in that same cycle. A faulty beat counter or slot offset shows at the very next beat as a wrong dword in one half of the bus. It can also show as a missing or misplaced eop, or as `pkt_ready` disagreeing with the model. The model compares data even in stalled cycles, so a beat that drifts while held is caught before it is sent.

// File: rtl/tlp_pack_pkg.sv
package tlp_pack_pkg;

    localparam int HDR_DW  = 4;
    localparam int BEAT_DW = 2;

    typedef logic [31:0] dword_t;

    typedef struct packed {
        logic        sop;
        logic        eop;
        logic [63:0] data;
    } tx_beat_t;

    // beats needed for header, optional gap slot and payload, rounded up
    function automatic int beat_count(input int len, input logic gap);
        return (HDR_DW + int'(gap) + len + BEAT_DW - 1) / BEAT_DW;
    endfunction

    // address bit 2 of a 4-dword header lives in bit 2 of dword 3
    function automatic logic addr_misaligned(input dword_t hdr_dw3);
        return hdr_dw3[2];
    endfunction

endpackage

// File: rtl/tlp_ready_hist.sv
module tlp_ready_hist #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rdy_in,
    output logic allow
);
    logic [LAT-1:0] hist_q;

    generate
        if (LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= rdy_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) hist_q <= '0;
                else     hist_q <= {hist_q[LAT-2:0], rdy_in};
            end
        end
    endgenerate

    assign allow = hist_q[LAT-1];
endmodule

// File: rtl/tlp_beat_seq.sv
module tlp_beat_seq
    import tlp_pack_pkg::*;
#(
    parameter int MAX_DW = 16,
    parameter int LEN_W  = 5,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              gap_in,
    input  logic              allow,
    output logic              pkt_ready,
    output logic              load,
    output logic              issue,
    output logic              first,
    output logic              last,
    output logic [BEAT_W-1:0] beat_idx
);
    logic              active;
    logic [BEAT_W-1:0] nbeats;

    assign issue     = active && allow;
    assign first     = (beat_idx == '0);
    assign last      = (beat_idx == nbeats - BEAT_W'(1));
    assign pkt_ready = !active || (issue && last);
    assign load      = pkt_valid && pkt_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            beat_idx <= '0;
            nbeats   <= '0;
        end else if (load) begin
            active   <= 1'b1;
            beat_idx <= '0;
            nbeats   <= BEAT_W'(beat_count(int'(pkt_len), gap_in));
        end else if (issue) begin
            if (last) active <= 1'b0;
            else      beat_idx <= beat_idx + BEAT_W'(1);
        end
    end

    // R7: a stalled beat keeps its place and the packet stays in flight
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (active && !issue) |=> (active && $stable(beat_idx)));

    // R9: offered length never exceeds the payload store
    p_len_range_r9: assert property (@(posedge clk) disable iff (rst)
        pkt_valid |-> (int'(pkt_len) <= MAX_DW));
endmodule

// File: rtl/tlp_beat_fmt.sv
module tlp_beat_fmt
    import tlp_pack_pkg::*;
#(
    parameter int MAX_DW = 16,
    parameter int LEN_W  = 5,
    parameter int BEAT_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [32*HDR_DW-1:0]  hdr_in,
    input  logic [LEN_W-1:0]      len_in,
    input  logic                  gap_in,
    input  logic [32*MAX_DW-1:0]  pay_in,
    input  logic [BEAT_W-1:0]     beat_idx,
    output logic [63:0]           data_out
);
    dword_t           hdr_q [HDR_DW];
    dword_t           pay_q [MAX_DW];
    logic [LEN_W-1:0] len_q;
    logic             gap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            gap_q <= 1'b0;
        end else if (load) begin
            len_q <= len_in;
            gap_q <= gap_in;
            for (int i = 0; i < HDR_DW; i++) hdr_q[i] <= hdr_in[32*i +: 32];
            for (int k = 0; k < MAX_DW; k++) pay_q[k] <= pay_in[32*k +: 32];
        end
    end

    // one slot selector per half of the beat
    genvar h;
    generate
        for (h = 0; h < BEAT_DW; h++) begin : g_half
            dword_t dw;
            int     slot;
            int     pidx;
            always_comb begin
                slot = BEAT_DW * int'(beat_idx) + h;
                pidx = slot - HDR_DW - int'(gap_q);
                dw   = '0;
                if (slot < HDR_DW) begin
                    dw = hdr_q[slot[1:0]];
                end else begin
                    for (int k = 0; k < MAX_DW; k++)
                        if (pidx == k && k < int'(len_q)) dw = pay_q[k];
                end
            end
        end
    endgenerate

    assign data_out = {g_half[1].dw, g_half[0].dw};
endmodule

// File: rtl/tlp_tx_packer.sv
module tlp_tx_packer
    import tlp_pack_pkg::*;
#(
    parameter int MAX_DW    = 16,
    parameter int READY_LAT = 2,
    parameter int LEN_W     = $clog2(MAX_DW + 1),
    parameter int PAY_W     = 32 * MAX_DW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pkt_valid,
    output logic              pkt_ready,
    input  logic [127:0]      pkt_hdr,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic [PAY_W-1:0]  pkt_payload,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic              tx_sop,
    output logic              tx_eop,
    output logic [63:0]       tx_data
);
    localparam int MAX_BEATS = (HDR_DW + 1 + MAX_DW + BEAT_DW - 1) / BEAT_DW;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);

    logic              allow, load, issue, first, last;
    logic              gap;
    logic [BEAT_W-1:0] beat_idx;
    tx_beat_t          beat;

    assign gap = addr_misaligned(pkt_hdr[96 +: 32]) && (pkt_len != '0);

    tlp_ready_hist #(.LAT(READY_LAT)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .rdy_in (tx_ready),
        .allow  (allow)
    );

    tlp_beat_seq #(.MAX_DW(MAX_DW), .LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt_len   (pkt_len),
        .gap_in    (gap),
        .allow     (allow),
        .pkt_ready (pkt_ready),
        .load      (load),
        .issue     (issue),
        .first     (first),
        .last      (last),
        .beat_idx  (beat_idx)
    );

    tlp_beat_fmt #(.MAX_DW(MAX_DW), .LEN_W(LEN_W), .BEAT_W(BEAT_W)) u_fmt (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .hdr_in   (pkt_hdr),
        .len_in   (pkt_len),
        .gap_in   (gap),
        .pay_in   (pkt_payload),
        .beat_idx (beat_idx),
        .data_out (beat.data)
    );

    assign beat.sop = issue && first;
    assign beat.eop = issue && last;

    assign tx_valid = issue;
    assign tx_sop   = beat.sop;
    assign tx_eop   = beat.eop;
    assign tx_data  = beat.data;

    // R2: a packet spans at least the two header beats
    p_sop_not_eop_r2: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !(tx_sop && tx_eop));

    // R1: framing flags never appear without valid
    p_flags_need_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |-> (!tx_sop && !tx_eop));

    generate
        if (READY_LAT == 2) begin : g_lat2_chk
            // R6: a beat only goes out when ready was seen two cycles back
            p_valid_after_ready_r6: assert property (@(posedge clk) disable iff (rst)
                tx_valid |-> $past(tx_ready, 2));

            // R8: an offer at eop yields sop next cycle when ready permits
            p_b2b_r8: assert property (@(posedge clk) disable iff (rst)
                (tx_valid && tx_eop && pkt_valid) |=>
                    (!$past(tx_ready, 2) || (tx_valid && tx_sop)));
        end
    endgenerate
endmodule

// File: tb/tb_tlp_tx_packer.sv
module tb_tlp_tx_packer;
    localparam int MAX_DW = 16;
    localparam int LEN_W  = $clog2(MAX_DW + 1);
    localparam int PAY_W  = 32 * MAX_DW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pkt_valid = 1'b0;
    logic              pkt_ready;
    logic [127:0]      pkt_hdr = '0;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic [PAY_W-1:0]  pkt_payload = '0;
    logic              tx_ready = 1'b0;
    logic              tx_valid, tx_sop, tx_eop;
    logic [63:0]       tx_data;

    always #10 clk = ~clk;

    tlp_tx_packer #(.MAX_DW(MAX_DW)) dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_hdr(pkt_hdr), .pkt_len(pkt_len), .pkt_payload(pkt_payload),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_data(tx_data)
    );

    typedef struct {
        logic        sop;
        logic        eop;
        logic [63:0] d;
        string       tag;
    } exp_t;

    typedef struct {
        logic [127:0]     hdr;
        int               len;
        logic [PAY_W-1:0] pay;
    } desc_t;

    exp_t  q[$];
    desc_t pend[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    r1 = 0, r2 = 0;
    int    mode = 0;
    int    cyc  = 0;

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected beats straight from the dword layout rules
    task automatic push_beats(input desc_t ds);
        logic [31:0] dw[$];
        bit mis = ds.hdr[98];
        for (int i = 0; i < 4; i++) dw.push_back(ds.hdr[32*i +: 32]);
        if (mis && ds.len > 0) dw.push_back(32'h0);
        for (int k = 0; k < ds.len; k++) dw.push_back(ds.pay[32*k +: 32]);
        if (dw.size() % 2 == 1) dw.push_back(32'h0);
        for (int b = 0; b < dw.size() / 2; b++) begin
            exp_t e;
            e.sop = (b == 0);
            e.eop = (b == dw.size() / 2 - 1);
            e.d   = {dw[2*b+1], dw[2*b]};
            if (ds.len == 0)           e.tag = "R10";
            else if (b < 2)            e.tag = "R2";
            else if (e.eop)            e.tag = "R5";
            else if (b == 2 && mis)    e.tag = "R4";
            else                       e.tag = "R3";
            q.push_back(e);
        end
    endtask

    function automatic desc_t mk(input int len, input bit mis);
        desc_t ds;
        for (int i = 0; i < 4; i++) ds.hdr[32*i +: 32] = $urandom;
        ds.hdr[98] = mis;
        ds.len = len;
        ds.pay = '0;
        for (int k = 0; k < MAX_DW; k++) ds.pay[32*k +: 32] = $urandom;
        return ds;
    endfunction

    function automatic bit ready_pat();
        case (mode)
            0: return 1'b1;
            1: return ($urandom % 4) != 0;
            default: return ((cyc / 5) % 2) == 0;
        endcase
    endfunction

    task automatic step();
        bit nr;
        @(negedge clk);
        cyc++;
        if (tx_valid) begin
            if (!r2) begin
                chk(0, "R6 beat without ready", 64'(tx_valid), 64'(0));
            end else if (q.size() == 0) begin
                chk(0, "R7 extra beat", 64'(tx_valid), 64'(0));
            end else begin
                exp_t e = q.pop_front();
                chk(tx_data == e.d, {e.tag, " data"}, tx_data, e.d);
                chk(tx_sop == e.sop, {e.tag, " sop"}, 64'(tx_sop), 64'(e.sop));
                chk(tx_eop == e.eop, {e.tag, " eop"}, 64'(tx_eop), 64'(e.eop));
            end
        end else begin
            chk(!tx_sop && !tx_eop, "R1 flags without valid",
                64'({tx_sop, tx_eop}), 64'(0));
            if (r2 && q.size() > 0)
                chk(0, q[0].sop ? "R8 missing sop beat" : "R7 missing beat",
                    64'(0), 64'(1));
            else if (q.size() > 0)
                chk(tx_data == q[0].d, "R7 held data", tx_data, q[0].d);
        end
        chk(pkt_ready == (q.size() == 0), "R9 pkt_ready",
            64'(pkt_ready), 64'(q.size() == 0));
        // drive next inputs
        nr = ready_pat();
        tx_ready = nr;
        if (pend.size() > 0) begin
            pkt_valid   = 1'b1;
            pkt_hdr     = pend[0].hdr;
            pkt_len     = LEN_W'(pend[0].len);
            pkt_payload = pend[0].pay;
        end else begin
            pkt_valid = 1'b0;
        end
        if (pkt_valid && pkt_ready) begin
            push_beats(pend[0]);
            void'(pend.pop_front());
        end
        r2 = r1;
        r1 = nr;
    endtask

    task automatic drain();
        int n = 0;
        while ((pend.size() > 0 || q.size() > 0) && n < 5000) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tx_valid && !tx_sop && !tx_eop, "R1 in reset",
            64'({tx_valid, tx_sop, tx_eop}), 64'(0));
        rst = 1'b0;
        @(negedge clk);
        chk(!tx_valid && !tx_sop && !tx_eop, "R1 after reset",
            64'({tx_valid, tx_sop, tx_eop}), 64'(0));
        r1 = 0; r2 = 0;

        // directed cases, ready always high, packets back to back (R8)
        mode = 0;
        pend.push_back(mk(4, 0));
        pend.push_back(mk(3, 0));
        pend.push_back(mk(1, 1));
        pend.push_back(mk(2, 1));
        pend.push_back(mk(0, 1));
        pend.push_back(mk(0, 0));
        pend.push_back(mk(MAX_DW, 1));
        pend.push_back(mk(MAX_DW, 0));
        pend.push_back(mk(5, 1));
        drain();

        // random ready
        mode = 1;
        for (int i = 0; i < 25; i++) pend.push_back(mk($urandom % (MAX_DW + 1), $urandom % 2));
        drain();

        // long stalls
        mode = 2;
        for (int i = 0; i < 15; i++) pend.push_back(mk($urandom % (MAX_DW + 1), $urandom % 2));
        drain();

        mode = 0;
        repeat (6) step();
        chk(q.size() == 0 && pend.size() == 0, "R7 all beats delivered",
            64'(q.size()), 64'(0));
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=%0d", q.size(), 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule